// File: doc/BRIEF.md
# Delayed Read Completion Slot

This block keeps the single outstanding delayed read of a bus target bridge. A requester's first read attempt gets a retry while the block starts a fetch on the far side. The block records the address and command code of that read. When the far side returns the data, the block keeps it. The original requester is expected to repeat the identical read. On that repeat it receives the stored data with a normal completion, and the slot opens for the next read.

The slot moves through three named states. SLOT_FREE holds nothing. SLOT_FETCH means a far-side fetch is under way. SLOT_HOLD means data is waiting to be collected. Five transitions connect them:
- accept: FREE to FETCH, on any read request.
- load: FETCH to HOLD, on the far-side completion strobe.
- claim: HOLD to FREE, on a request whose address and command both match the stored ones.
- expire: HOLD to FREE, when the stored data sits uncollected for 2^EXPIRE_W clock edges.
- stay: every other case.

While the slot is busy, any request that does not collect the data is held off with retry and starts no fetch. Expiry frees the slot silently, and the next request is then accepted as a new read. Each response is registered and appears one cycle after the request is sampled.

Top module: `rd_hold_slot`

## Requirements
- R1: After reset the slot is free and rsp_retry, rsp_data_valid and fetch_start are all low.
- R2: A request sampled while the slot is free is answered one cycle later with rsp_retry=1 and fetch_start=1, and fetch_addr/fetch_cmd equal the request's address and command.
- R3: A request sampled while a fetch is under way, whether matching or not, gets rsp_retry=1 and fetch_start=0.
- R4: fill_valid during a fetch stores fill_data and moves the slot to holding. fill_valid in the free or holding state has no effect.
- R5: A request whose address and command both equal the stored ones, sampled while holding, gets rsp_data_valid=1 with rsp_data equal to the stored data and rsp_retry=0, and frees the slot.
- R6: A request that differs in address or in command code, sampled while holding, gets rsp_retry=1 and fetch_start=0, and the stored data stays collectable.
- R7: Stored data is discarded on the 2^EXPIRE_W-th clock edge after the edge that stored it. A request sampled on that edge or earlier is answered against the stored entry. A request sampled later finds the slot free.
- R8: After expiry, the next request of any address is accepted with rsp_retry=1 and fetch_start=1.
- R9: Expiry produces no pulse on rsp_retry, rsp_data_valid or fetch_start.
- R10: rsp_retry and rsp_data_valid are never high together, and fetch_start is high only together with rsp_retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Request command code |
| fill_valid | input | 1 | Far-side completion strobe |
| fill_data | input | DATA_W | Far-side read data |
| rsp_retry | output | 1 | Terminate the request with retry |
| rsp_data_valid | output | 1 | Normal completion with rsp_data |
| rsp_data | output | DATA_W | Stored read data, zero when not valid |
| fetch_start | output | 1 | Start a far-side fetch |
| fetch_addr | output | ADDR_W | Address of the fetch |
| fetch_cmd | output | CMD_W | Command of the fetch |

## Verification
The bench sweeps the arrival edge of both a mismatching and a matching request across every offset from one edge after the data is stored to two edges past expiry. The aim is to catch an expiry that lands one cycle early or late. Such a timer would either accept a new read while data is still held, or keep holding off requests after the discard. A comparator that ignores the command code would hand stored data to a request with a different command. A design that reacts to fill_valid outside a fetch would overwrite stored data or return data that was never requested. A design that flags the discard would show a spurious retry or data pulse on the expiry edge.

// File: rtl/rd_hold_pkg.sv
package rd_hold_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_FETCH = 2'd1,
        SLOT_HOLD  = 2'd2
    } slot_state_t;
endpackage

// File: rtl/rd_hold_cmp.sv
module rd_hold_cmp #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [CMD_W-1:0]  tag_cmd,
    output logic              hit
);
    localparam int KEY_W = ADDR_W + CMD_W;

    logic [KEY_W-1:0] diff;

    genvar b;
    generate
        for (b = 0; b < KEY_W; b++) begin : g_bit
            if (b < ADDR_W) begin : g_addr
                assign diff[b] = req_addr[b] ^ tag_addr[b];
            end else begin : g_cmd
                assign diff[b] = req_cmd[b-ADDR_W] ^ tag_cmd[b-ADDR_W];
            end
        end
    endgenerate

    assign hit = ~|diff;
endmodule

// File: rtl/rd_hold_timer.sv
module rd_hold_timer #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic stop,
    output logic expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (stop) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == CNT_MAX);

    // R7: loading restarts the count from zero
    p_load_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (run_q && cnt_q == '0));

    // R7: an idle timer does not advance
    p_idle_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/rd_hold_slot.sv
module rd_hold_slot
    import rd_hold_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CMD_W    = 4,
    parameter int DATA_W   = 32,
    parameter int EXPIRE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_retry,
    output logic              rsp_data_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fetch_start,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [CMD_W-1:0]  fetch_cmd
);
    slot_state_t       state_q, state_d;
    logic [ADDR_W-1:0] tag_addr_q;
    logic [CMD_W-1:0]  tag_cmd_q;
    logic [DATA_W-1:0] held_q;
    logic              hit, expired;
    logic              accept, load, claim, expire_now;

    rd_hold_cmp #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_cmp (
        .req_addr (req_addr),
        .req_cmd  (req_cmd),
        .tag_addr (tag_addr_q),
        .tag_cmd  (tag_cmd_q),
        .hit      (hit)
    );

    rd_hold_timer #(.CNT_W(EXPIRE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .stop    (claim || expire_now),
        .expired (expired)
    );

    assign accept     = req_valid  && (state_q == SLOT_FREE);
    assign load       = fill_valid && (state_q == SLOT_FETCH);
    assign claim      = req_valid  && (state_q == SLOT_HOLD) && hit;
    assign expire_now = (state_q == SLOT_HOLD) && expired && !claim;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (accept) state_d = SLOT_FETCH;
            SLOT_FETCH: if (load)   state_d = SLOT_HOLD;
            SLOT_HOLD:  if (claim || expire_now) state_d = SLOT_FREE;
            default:    state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_addr_q <= '0;
            tag_cmd_q  <= '0;
            held_q     <= '0;
        end else begin
            if (accept) begin
                tag_addr_q <= req_addr;
                tag_cmd_q  <= req_cmd;
            end
            if (load) held_q <= fill_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_retry      <= 1'b0;
            rsp_data_valid <= 1'b0;
            rsp_data       <= '0;
            fetch_start    <= 1'b0;
        end else begin
            rsp_retry      <= req_valid && !claim;
            rsp_data_valid <= claim;
            rsp_data       <= claim ? held_q : '0;
            fetch_start    <= accept;
        end
    end

    assign fetch_addr = tag_addr_q;
    assign fetch_cmd  = tag_cmd_q;

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && state_q == SLOT_FREE) |=> (rsp_retry && fetch_start));

    p_fetching_holdoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && state_q == SLOT_FETCH) |=> (rsp_retry && !fetch_start));

    p_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && state_q == SLOT_HOLD && hit) |=> (rsp_data_valid && state_q == SLOT_FREE));

    p_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && state_q == SLOT_HOLD && !hit) |=> (rsp_retry && !fetch_start));

    p_expire_in_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> (state_q == SLOT_HOLD));

    p_quiet_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !req_valid) |=> (!rsp_retry && !rsp_data_valid && !fetch_start));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_retry && rsp_data_valid) && (!fetch_start || rsp_retry));
endmodule

// File: tb/sim_rd_hold_slot.sv
module sim_rd_hold_slot;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16, CMD_W = 4, DATA_W = 16, EXPIRE_W = 4;
    localparam int LIMIT = 1 << EXPIRE_W;
    localparam logic [CMD_W-1:0] C_MEM = 4'h6, C_IO = 4'h2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, fill_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CMD_W-1:0]  req_cmd = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic rsp_retry, rsp_data_valid, fetch_start;
    logic [DATA_W-1:0] rsp_data;
    logic [ADDR_W-1:0] fetch_addr;
    logic [CMD_W-1:0]  fetch_cmd;

    int n_chk = 0, n_bad = 0;
    bit timed_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rd_hold_slot #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .EXPIRE_W(EXPIRE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
        .fill_valid(fill_valid), .fill_data(fill_data), .rsp_retry(rsp_retry),
        .rsp_data_valid(rsp_data_valid), .rsp_data(rsp_data), .fetch_start(fetch_start),
        .fetch_addr(fetch_addr), .fetch_cmd(fetch_cmd));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // response triple packed as {retry, data_valid, fetch_start}
    function automatic logic [31:0] rsp3();
        return {29'd0, rsp_retry, rsp_data_valid, fetch_start};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_req(input logic [ADDR_W-1:0] a, input logic [CMD_W-1:0] c);
        req_valid = 1'b1; req_addr = a; req_cmd = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [DATA_W-1:0] d);
        fill_valid = 1'b1; fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // reset, open a delayed read of (a,c) and store d; returns just after the storing edge
    task automatic open_hold(input logic [ADDR_W-1:0] a, input logic [CMD_W-1:0] c,
                             input logic [DATA_W-1:0] d);
        do_reset();
        do_req(a, c);
        check("R2 first attempt retry+fetch", rsp3(), 32'b101);
        check("R2 fetch address", {16'd0, fetch_addr}, {16'd0, a});
        do_fill(d);
    endtask

    task automatic run_tests();
        do_reset();
        check("R1 outputs after reset", rsp3(), 32'b000);

        // R4: fill while free is ignored
        do_fill(16'hBEEF);
        do_req(16'h0040, C_MEM);
        check("R4 fill in free ignored -> new fetch", rsp3(), 32'b101);
        check("R2 fetch cmd", {28'd0, fetch_cmd}, {28'd0, C_MEM});
        // R3: requests while fetching
        do_req(16'h0040, C_MEM);
        check("R3 same request while fetching", rsp3(), 32'b100);
        do_req(16'h0044, C_MEM);
        check("R3 other request while fetching", rsp3(), 32'b100);
        do_fill(16'h1234);
        check("R9 no pulse on store", rsp3(), 32'b000);
        // R4: fill while holding ignored
        do_fill(16'h9999);
        // R6: same address other command
        do_req(16'h0040, C_IO);
        check("R6 command differs -> retry", rsp3(), 32'b100);
        do_req(16'h0040, C_MEM);
        check("R5 claim response", rsp3(), 32'b010);
        check("R4/R5 held data kept", {16'd0, rsp_data}, 32'h1234);
        do_req(16'h0080, C_IO);
        check("R5 slot freed after claim", rsp3(), 32'b101);
        check("R2 fetch cmd io", {28'd0, fetch_cmd}, {28'd0, C_IO});

        // sweep: mismatching request at every offset k around expiry
        for (int k = 1; k <= LIMIT + 2; k++) begin
            logic [CMD_W-1:0] oc;
            oc = (k % 2) ? C_MEM : C_IO;
            open_hold(16'h0100, C_MEM, 16'h5A00 + 16'(k));
            repeat (k - 1) @(negedge clk);
            do_req((k % 2) ? 16'h0104 : 16'h0100, oc);
            if (k <= LIMIT) begin
                check("R6/R7 different request held off", rsp3(), 32'b100);
                if (k < LIMIT) begin
                    do_req(16'h0100, C_MEM);
                    check("R6 data still collectable", rsp3(), 32'b010);
                    check("R6 data value", {16'd0, rsp_data}, {16'd0, 16'h5A00 + 16'(k + 0)});
                end
            end else begin
                check("R8 accepted after expiry", rsp3(), 32'b101);
                check("R8 fetch addr after expiry", {16'd0, fetch_addr},
                      {16'd0, (k % 2) ? 16'h0104 : 16'h0100});
            end
        end

        // sweep: matching request at every offset k around expiry
        for (int k = 1; k <= LIMIT + 2; k++) begin
            open_hold(16'h0200, C_IO, 16'hC000 + 16'(k));
            repeat (k - 1) @(negedge clk);
            do_req(16'h0200, C_IO);
            if (k <= LIMIT) begin
                check("R5/R7 match collects data", rsp3(), 32'b010);
                check("R5 data value", {16'd0, rsp_data}, {16'd0, 16'hC000 + 16'(k)});
            end else begin
                check("R7 match after expiry is a new read", rsp3(), 32'b101);
            end
        end

        // R9: idle across the expiry edge shows no pulse
        open_hold(16'h0300, C_MEM, 16'h7777);
        for (int k = 1; k <= LIMIT + 1; k++) begin
            @(negedge clk);
            check("R9 quiet during hold and expiry", rsp3(), 32'b000);
        end
        do_req(16'h0310, C_IO);
        check("R8 slot free after silent expiry", rsp3(), 32'b101);
    endtask

    initial begin
        fork
            begin run_tests(); end
            begin repeat (150000) @(posedge clk); timed_out = 1'b1; end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule